// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the lowest layer of an I2C master. A controller hands it one bus event at a time: a START condition, a STOP condition, a byte to send, or a byte to receive along with the acknowledge value to return. The engine drives the open-drain bus through two pull-low enables and watches both wires through two-flop synchronizers. When the event ends it pulses `done` with a success flag. After a write it also reports the acknowledge it saw, and after a read it reports the received byte.

All bus timing is counted in quarter-bit units. The controller supplies the length of one unit in clock cycles, and the engine applies a lower limit to it. Each time the engine lets SCL go, it polls SCL once per quarter until the wire actually reads high, which lets a target stretch the clock. A stretch that goes on too long ends the event with a failure. If SDA is held low when a START is attempted, the START is retried a bounded number of times. After a STOP, the engine checks that SDA really rose. Any failure leaves both wires released.

Command encoding on `cmd_op`: 0 = START, 1 = STOP, 2 = byte write, 3 = byte read.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both `scl_low_en` and `sda_low_en` are 0 (both wires released).
- R2: `cmd_valid` is taken only while `busy` is 0. A request raised while busy is ignored. A request still present in the cycle `done` is high is accepted on the following clock edge.
- R3: One quarter lasts max(`quarter_cyc`, MIN_Q) clock cycles, with the value captured when the command is accepted. A STOP without stretching spans four quarters, so its duration grows by 4 cycles for each extra cycle per quarter.
- R4: A write sends `cmd_data` MSB first. SDA changes only while SCL is low, and the byte takes 9 SCL high pulses in total.
- R5: After a write, `ack_seen` is 1 when SDA read low during the 9th SCL high pulse and 0 when it read high.
- R6: A read returns the 8 bits sampled on SCL high pulses 1 to 8, MSB first, on `rd_data`. On the 9th pulse SDA is held low when `cmd_ack`=1 and released when `cmd_ack`=0.
- R7: A START makes SDA fall while SCL is high. It ends with `ok`=1 and both wires held low.
- R8: If SDA still reads low after being released during a START, the attempt is repeated. After START_TRIES such attempts the START ends with `ok`=0.
- R9: After releasing SCL the engine waits until SCL reads high, polling once per quarter. If a target holds SCL low for fewer than STRETCH_POLLS polls, the event still succeeds. Otherwise it ends with `ok`=0.
- R10: A STOP makes SDA rise while SCL is high. If SDA does not read high within three polls spaced a quarter apart, the STOP ends with `ok`=0.
- R11: Whenever `done` is high with `ok`=0, both pull-low enables are 0.
- R12: `done` is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write, 3 read |
| cmd_data | input | 8 | Byte to send |
| cmd_ack | input | 1 | Read only: 1 = acknowledge (more bytes follow) |
| quarter_cyc | input | QW | Quarter-bit length in clock cycles |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Success flag, valid with `done` |
| ack_seen | output | 1 | Acknowledge seen after a write |
| rd_data | output | 8 | Byte received by a read |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_low_en | output | 1 | Pull SCL low |
| sda_low_en | output | 1 | Pull SDA low |

## Verification
Completion of one command and acceptance of the next can fall in the same cycle, because `done` is reported from the idle state. The bench raises a STOP request in the middle of a write and holds it through the write's `done` cycle. It then checks three things: the write still delivers its byte and acknowledge unchanged, the engine is busy in the very next cycle, and exactly one STOP condition shows up on the wires.

// File: rtl/i2c_bit_master.sv
module i2c_bit_master #(
  parameter int QW            = 8,
  parameter int MIN_Q         = 3,
  parameter int STRETCH_POLLS = 16,
  parameter int START_TRIES   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [7:0]    cmd_data,
  input  logic          cmd_ack,
  input  logic [QW-1:0] quarter_cyc,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          ack_seen,
  output logic [7:0]    rd_data,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_low_en,
  output logic          sda_low_en
);
  localparam int PW = $clog2(STRETCH_POLLS + 1);
  localparam int TW = $clog2(START_TRIES + 3);
  localparam logic [1:0] OP_START = 2'd0, OP_STOP = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;

  typedef enum logic [4:0] {
    S_IDLE, S_DLY, S_POLL, S_FIN, S_FAIL,
    T0, T1, T2, T3, T4,
    P0, P1, P2, P3, P4,
    W0, W1, W2, W3, WA0, WA1, WA2, WA3, WA4,
    RS, R0, R1, RA1, RA2, RA3, RA4
  } st_t;

  st_t st, ret;
  logic [QW-1:0] tmr, qlat;
  logic [1:0]    nq, op_q;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tries;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          more_q, scl_drv, sda_drv;
  logic          scl_m, scl_s, sda_m, sda_s;

  wire [QW-1:0] q_eff = (quarter_cyc < QW'(MIN_Q)) ? QW'(MIN_Q) : quarter_cyc;
  wire          tick  = (tmr == QW'(1));

  assign busy       = (st != S_IDLE);
  assign scl_low_en = scl_drv;
  assign sda_low_en = sda_drv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_m, scl_s, sda_m, sda_s} <= 4'b1111;
    else        {scl_m, scl_s, sda_m, sda_s} <= {scl_in, scl_m, sda_in, sda_m};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE; tmr <= '0; qlat <= QW'(MIN_Q); nq <= '0;
      op_q <= OP_START; pcnt <= '0; tries <= '0; bitn <= '0; sh <= '0;
      more_q <= 1'b0; scl_drv <= 1'b0; sda_drv <= 1'b0;
      done <= 1'b0; ok <= 1'b0; ack_seen <= 1'b0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          qlat <= q_eff; op_q <= cmd_op; sh <= cmd_data; more_q <= cmd_ack;
          bitn <= 3'd7; tries <= '0;
          case (cmd_op)
            OP_START: st <= T0;
            OP_STOP:  st <= P0;
            OP_WR:    st <= W0;
            default:  st <= RS;
          endcase
        end
        S_DLY: if (tick) begin
          if (nq == 2'd1) st <= ret;
          else begin nq <= nq - 2'd1; tmr <= qlat; end
        end else tmr <= tmr - 1'b1;
        S_POLL: if (tick) begin
          if (scl_s) st <= ret;
          else if (pcnt == PW'(STRETCH_POLLS - 1)) st <= S_FAIL;
          else begin pcnt <= pcnt + 1'b1; tmr <= qlat; end
        end else tmr <= tmr - 1'b1;
        S_FIN:  begin done <= 1'b1; ok <= 1'b1; st <= S_IDLE; end
        S_FAIL: begin
          done <= 1'b1; ok <= 1'b0; scl_drv <= 1'b0; sda_drv <= 1'b0; st <= S_IDLE;
        end
        T0: begin scl_drv <= 1'b0; st <= S_DLY; ret <= T1; nq <= 2'd1; tmr <= qlat; end
        T1: begin sda_drv <= 1'b0; st <= S_DLY; ret <= T2; nq <= 2'd1; tmr <= qlat; end
        T2: if (!sda_s) begin
          if (tries == TW'(START_TRIES - 1)) st <= S_FAIL;
          else begin tries <= tries + 1'b1; st <= T1; end
        end else begin st <= S_POLL; ret <= T3; tmr <= qlat; pcnt <= '0; end
        T3: begin sda_drv <= 1'b1; st <= S_DLY; ret <= T4; nq <= 2'd1; tmr <= qlat; end
        T4: begin scl_drv <= 1'b1; st <= S_DLY; ret <= S_FIN; nq <= 2'd1; tmr <= qlat; end
        P0: begin scl_drv <= 1'b1; st <= S_DLY; ret <= P1; nq <= 2'd1; tmr <= qlat; end
        P1: begin sda_drv <= 1'b1; st <= S_DLY; ret <= P2; nq <= 2'd1; tmr <= qlat; end
        P2: begin scl_drv <= 1'b0; st <= S_POLL; ret <= P3; tmr <= qlat; pcnt <= '0; end
        P3: begin
          sda_drv <= 1'b0; tries <= '0;
          st <= S_DLY; ret <= P4; nq <= 2'd1; tmr <= qlat;
        end
        P4: if (sda_s) st <= S_FIN;
            else if (tries == TW'(2)) st <= S_FAIL;
            else begin tries <= tries + 1'b1; st <= S_DLY; ret <= P4; nq <= 2'd1; tmr <= qlat; end
        W0: begin st <= S_DLY; ret <= W1; nq <= 2'd1; tmr <= qlat; end
        W1: begin sda_drv <= ~sh[7]; st <= S_DLY; ret <= W2; nq <= 2'd1; tmr <= qlat; end
        W2: begin scl_drv <= 1'b0; st <= S_POLL; ret <= W3; tmr <= qlat; pcnt <= '0; end
        W3: begin
          scl_drv <= 1'b1;
          if (bitn == 3'd0) st <= WA0;
          else begin bitn <= bitn - 3'd1; sh <= {sh[6:0], 1'b0}; st <= W0; end
        end
        WA0: begin st <= S_DLY; ret <= WA1; nq <= 2'd1; tmr <= qlat; end
        WA1: begin sda_drv <= 1'b0; st <= S_DLY; ret <= WA2; nq <= 2'd1; tmr <= qlat; end
        WA2: begin scl_drv <= 1'b0; st <= S_POLL; ret <= WA3; tmr <= qlat; pcnt <= '0; end
        WA3: begin ack_seen <= ~sda_s; st <= S_DLY; ret <= WA4; nq <= 2'd2; tmr <= qlat; end
        WA4: begin scl_drv <= 1'b1; st <= S_DLY; ret <= S_FIN; nq <= 2'd2; tmr <= qlat; end
        RS: begin sda_drv <= 1'b0; st <= S_DLY; ret <= R0; nq <= 2'd1; tmr <= qlat; end
        R0: begin scl_drv <= 1'b0; st <= S_POLL; ret <= R1; tmr <= qlat; pcnt <= '0; end
        R1: begin
          sh <= {sh[6:0], sda_s}; scl_drv <= 1'b1; bitn <= bitn - 3'd1;
          st <= S_DLY; tmr <= qlat;
          ret <= (bitn == 3'd0) ? RA1 : R0;
          nq  <= (bitn == 3'd0) ? 2'd3 : 2'd2;
        end
        RA1: begin
          rd_data <= sh; sda_drv <= more_q;
          st <= S_DLY; ret <= RA2; nq <= 2'd1; tmr <= qlat;
        end
        RA2: begin scl_drv <= 1'b0; st <= S_POLL; ret <= RA3; tmr <= qlat; pcnt <= '0; end
        RA3: begin scl_drv <= 1'b1; st <= S_DLY; ret <= RA4; nq <= 2'd1; tmr <= qlat; end
        RA4: begin sda_drv <= 1'b0; st <= S_DLY; ret <= S_FIN; nq <= 2'd1; tmr <= qlat; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  fail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (!scl_low_en && !sda_low_en));
  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_q) && $stable(qlat)));
  // R9
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (pcnt < PW'(STRETCH_POLLS)));
  // R4
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == OP_WR || op_q == OP_RD) && !scl_low_en && !$past(scl_low_en))
      |-> $stable(sda_low_en));
  // R3
  quarter_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (qlat >= QW'(MIN_Q)));
  // R10
  stop_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P4) |-> (!scl_low_en && !sda_low_en));
endmodule

// File: tb/i2c_bit_master_tb.sv
module i2c_bit_master_tb;
  localparam int QW = 8;
  localparam logic [1:0] OP_START = 2'd0, OP_STOP = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ack = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic [QW-1:0] quarter_cyc = 8'd4;
  logic busy, done, ok, ack_seen, scl_low_en, sda_low_en;
  logic [7:0] rd_data;
  logic tgt_scl_hold = 1'b0, tgt_sda_low = 1'b0, force_sda = 1'b0;
  logic scl_line, sda_line;
  int tgt_mode = 0;
  logic [7:0] tgt_byte = '0;
  int fcnt = 0, pcnt = 0, starts = 0, stops = 0;
  logic [8:0] cap = '0;
  int checks = 0, bad = 0;
  logic r_ok, r_ack;
  logic [7:0] r_rd;
  int r_dur;

  always #5 clk = ~clk;

  assign scl_line = !scl_low_en && !tgt_scl_hold;
  assign sda_line = !sda_low_en && !tgt_sda_low && !force_sda;

  i2c_bit_master #(.QW(QW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ack(cmd_ack), .quarter_cyc(quarter_cyc),
    .busy(busy), .done(done), .ok(ok), .ack_seen(ack_seen), .rd_data(rd_data),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_low_en(scl_low_en), .sda_low_en(sda_low_en));

  always @(negedge scl_line) begin
    fcnt = fcnt + 1;
    if (tgt_mode == 1) tgt_sda_low = (fcnt == 8);
    else if (tgt_mode == 3) tgt_sda_low = (fcnt < 8) ? !tgt_byte[7 - fcnt] : 1'b0;
    else tgt_sda_low = 1'b0;
  end
  always @(posedge scl_line) begin cap = {cap[7:0], sda_line}; pcnt = pcnt + 1; end
  always @(negedge sda_line) if (scl_line) starts = starts + 1;
  always @(posedge sda_line) if (scl_line) stops = stops + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [7:0] d, input logic f);
    int n = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_ack = f;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk("R12 done never seen", 0, 1);
    r_ok = ok; r_ack = ack_seen; r_rd = rd_data; r_dur = n;
  endtask

  task automatic arm(input int mode, input logic [7:0] b);
    fcnt = 0; pcnt = 0; cap = '0; tgt_mode = mode; tgt_byte = b;
    tgt_sda_low = (mode == 3) ? !b[7] : 1'b0;
  endtask

  // {is_read, byte, flag}: write flag = target acknowledges, read flag = more bytes
  localparam logic [9:0] VEC [7] = '{
    {1'b0, 8'hA5, 1'b1}, {1'b0, 8'h3C, 1'b0}, {1'b0, 8'h00, 1'b1}, {1'b0, 8'hFF, 1'b1},
    {1'b1, 8'h96, 1'b1}, {1'b1, 8'h5A, 1'b0}, {1'b1, 8'h01, 1'b1}};

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int d1, d3, d6, s0;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 lines after reset", {scl_low_en, sda_low_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    s0 = starts;
    arm(0, 0); run(OP_START, 0, 0);
    chk("R7 start ok", r_ok, 1);
    chk("R7 start lines held low", {scl_low_en, sda_low_en}, 2'b11);
    chk("R7 start edge count", starts - s0, 1);

    for (int i = 0; i < 7; i++) begin
      logic rd; logic [7:0] b; logic f;
      {rd, b, f} = VEC[i];
      if (!rd) begin
        arm(f ? 1 : 2, b); run(OP_WR, b, 0);
        chk("R4 write ok", r_ok, 1);
        chk("R4 write bits MSB first", cap[8:1], b);
        chk("R4 write clock count", pcnt, 9);
        chk("R5 ack_seen", r_ack, f);
      end else begin
        arm(3, b); run(OP_RD, 0, f);
        chk("R6 read data", r_rd, b);
        chk("R6 read ack bit", cap[0], !f);
        chk("R6 read ok", r_ok, 1);
      end
    end
    s0 = stops;
    arm(0, 0); run(OP_STOP, 0, 0);
    chk("R10 stop ok", r_ok, 1);
    chk("R10 stop edge count", stops - s0, 1);
    chk("R10 lines released", {scl_low_en, sda_low_en}, 0);

    // R3 quarter clamp and scaling
    quarter_cyc = 8'd1; run(OP_START, 0, 0); run(OP_STOP, 0, 0); d1 = r_dur;
    quarter_cyc = 8'd3; run(OP_START, 0, 0); run(OP_STOP, 0, 0); d3 = r_dur;
    quarter_cyc = 8'd6; run(OP_START, 0, 0); run(OP_STOP, 0, 0); d6 = r_dur;
    chk("R3 quarter floor", d1, d3);
    chk("R3 stop spans four quarters", d6 - d3, 12);
    quarter_cyc = 8'd4;

    // R9 stretch within limit
    run(OP_START, 0, 0);
    arm(1, 8'h5C); run(OP_WR, 8'h5C, 0); d1 = r_dur;
    arm(1, 8'h5C); tgt_scl_hold = 1'b1;
    fork
      run(OP_WR, 8'h5C, 0);
      begin repeat (30) @(negedge clk); tgt_scl_hold = 1'b0; end
    join
    chk("R9 stretched write ok", r_ok, 1);
    chk("R9 stretched write longer", r_dur > d1, 1);
    chk("R9 stretched write bits", cap[8:1], 8'h5C);

    // R9 / R11 stretch timeout
    arm(1, 8'h11); tgt_scl_hold = 1'b1; run(OP_WR, 8'h11, 0);
    chk("R9 timeout fails", r_ok, 0);
    chk("R11 lines released on fail", {scl_low_en, sda_low_en}, 0);
    @(negedge clk); chk("R12 done one cycle", done, 0);
    tgt_scl_hold = 1'b0;
    repeat (4) @(negedge clk);

    // R8 start retries exhausted
    force_sda = 1'b1; run(OP_START, 0, 0);
    chk("R8 start stuck fails", r_ok, 0);
    chk("R11 lines after start fail", {scl_low_en, sda_low_en}, 0);
    force_sda = 1'b0;
    repeat (4) @(negedge clk);

    // R10 stop with SDA stuck
    run(OP_START, 0, 0);
    force_sda = 1'b1; run(OP_STOP, 0, 0);
    chk("R10 stop stuck fails", r_ok, 0);
    force_sda = 1'b0;
    repeat (4) @(negedge clk);

    // R2 request ignored while busy, accepted in the done cycle
    run(OP_START, 0, 0);
    arm(1, 8'hC3); s0 = stops;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = OP_WR; cmd_data = 8'hC3;
    @(negedge clk); cmd_op = OP_STOP;
    while (!done) @(negedge clk);
    chk("R2 write unaffected ok", ok, 1);
    chk("R2 write unaffected ack", ack_seen, 1);
    chk("R2 write unaffected bits", cap[8:1], 8'hC3);
    @(negedge clk); cmd_valid = 1'b0;
    chk("R2 accepted in done cycle", busy, 1);
    while (!done) @(negedge clk);
    chk("R2 queued stop ok", ok, 1);
    begin
      int dn = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (done) dn++; end
      chk("R12 no extra done", dn, 0);
    end
    chk("R2 single stop", stops - s0, 1);
    chk("R2 idle afterwards", busy, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule